// File: doc/BRIEF.md
# Operand Forwarding and Interlock Controller

This block sits beside the operand-fetch stage of an in-order five-stage scalar pipeline. It is purely combinational. Each source operand of the instruction in operand fetch is compared against the destination of the instruction one slot ahead, which is in execute, and the instruction two slots ahead, which is in write-back. The block then picks one of four values for that operand: the register file, the ALU result leaving execute, the load data returning from the data cache, or the result held in write-back.

Some dependencies cannot be covered by a bypass. One case is a load in execute whose data is not back yet. Another is a register file with one shared read/write port that a write-back is already using. In both cases the block raises a hold for the front of the pipe. The hold freezes the PC, the fetch/decode register and the decode/operand register. It also raises a bubble request so that a no-op is loaded into the operand/execute register for each held cycle.

The instruction in operand fetch never reorders against older instructions, so only read-after-write dependencies are examined.

Top module: `opnd_hazard_unit`

## Requirements
- R1: With no valid matching producer, every operand select is 0 (register file) and `fe_hold` and `ex_bubble` are low.
- R2: A valid source equal to the destination of a register-writing non-load instruction in execute gets select code 1 (ALU result), with no hold caused by that operand.
- R3: A valid source equal to the destination of a register-writing non-load instruction in write-back, and not matched in execute, gets select code 3 (write-back result).
- R4: The same match against a load in write-back gets select code 2 (load data path).
- R5: A valid source equal to the destination of a load in execute raises `fe_hold` and `ex_bubble` together.
- R6: When execute and write-back both write the matched register, execute wins: code 1 for a non-load, or a hold for a load.
- R7: With `ZERO_REG_HARDWIRED`=1, register number 0 never matches. A source of 0 keeps select 0 and causes no hold, and a write-back to register 0 does not occupy the shared port.
- R8: A source whose valid bit is low, or a producer whose write-enable is low, never produces a forward or a hold, whatever its register numbers and load flag.
- R9: With `SHARED_RF_PORT`=1, a register-writing instruction in write-back plus any valid operand that still needs a register-file read raises `fe_hold` and `ex_bubble`. Operands that are all forwarded cause no such hold. With `SHARED_RF_PORT`=0 this hold never happens.
- R10: Each operand is resolved on its own. Operand k uses `of_src[5k+4:5k]` (default width 5, operand 0 in the low bits) and drives `opnd_sel[2k+1:2k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| of_src | input | NUM_SRC*REG_W | Source register numbers of the operand-fetch instruction |
| of_src_vld | input | NUM_SRC | Source-used flags |
| ex_dst | input | REG_W | Destination register of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| wb_dst | input | REG_W | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_load | input | 1 | Write-back instruction is a load |
| opnd_sel | output | NUM_SRC*2 | Per-operand source select (0 RF, 1 ALU, 2 load, 3 write-back) |
| fe_hold | output | 1 | Freeze PC and the two front pipeline registers |
| ex_bubble | output | 1 | Load a no-op into the operand/execute register |

## Verification
The bench builds two copies side by side, both with two 5-bit operands and a hard-wired register 0. One has `SHARED_RF_PORT`=1 and the other has `SHARED_RF_PORT`=0. Driving both with identical stimulus separates the port-conflict hold from the load-use interlock: a write-back with an operand that still reads the register file must stall only the shared-port copy. A load-use must stall both. Register-0 cases exercise the hard-wired variant on both the source side and the write-back side.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    SEL_RF   = 2'd0,
    SEL_ALU  = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_WB   = 2'd3
  } opnd_src_e;

  localparam int SEL_W = 2;

  // A producer is live when it writes and its target is not the constant register.
  function automatic logic producer_live(input logic wr, input logic dst_is_zero,
                                         input logic zero_hard);
    return wr && !(zero_hard && dst_is_zero);
  endfunction

endpackage

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int ZERO_HARD = 1
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_vld,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  input  logic             wb_load,
  output opnd_src_e        sel,
  output logic             ld_wait,
  output logic             rf_read
);

  localparam logic ZH = (ZERO_HARD != 0);

  function automatic logic reg_hit(input logic [REG_W-1:0] s, input logic v,
                                   input logic [REG_W-1:0] d, input logic w);
    return v && (s == d) && producer_live(w, d == '0, ZH);
  endfunction

  logic src_live, ex_hit, wb_hit;

  always_comb begin
    src_live = src_vld && !(ZH && src == '0);
    ex_hit   = reg_hit(src, src_vld, ex_dst, ex_wr);
    wb_hit   = reg_hit(src, src_vld, wb_dst, wb_wr);
    sel      = SEL_RF;
    ld_wait  = 1'b0;
    if (ex_hit) begin
      if (ex_load) ld_wait = 1'b1;
      else         sel     = SEL_ALU;
    end else if (wb_hit) begin
      sel = wb_load ? SEL_LOAD : SEL_WB;
    end
    rf_read = src_live && !ex_hit && !wb_hit;

    // Youngest producer first.
    if (ex_hit && wb_hit) begin
      assert_ex_first_R6: assert (sel == SEL_ALU || ld_wait);
    end
    if (ZH && src == '0) begin
      assert_r0_inert_R7: assert (sel == SEL_RF && !ld_wait && !rf_read);
    end
    if (!src_vld) begin
      assert_idle_src_R8: assert (sel == SEL_RF && !ld_wait && !rf_read);
    end
    if (sel == SEL_LOAD) begin
      assert_load_path_R4: assert (wb_load && wb_hit && !ex_hit);
    end
  end

endmodule

// File: rtl/hzd_stall.sv
module hzd_stall
  import hzd_pkg::*;
#(
  parameter int NUM_SRC   = 2,
  parameter int REG_W     = 5,
  parameter int SHARED    = 1,
  parameter int ZERO_HARD = 1
) (
  input  logic [NUM_SRC-1:0] ld_wait,
  input  logic [NUM_SRC-1:0] rf_read,
  input  logic [REG_W-1:0]   wb_dst,
  input  logic               wb_wr,
  output logic               fe_hold,
  output logic               ex_bubble
);

  logic ld_use, wb_live, port_clash;

  always_comb begin
    ld_use     = |ld_wait;
    wb_live    = producer_live(wb_wr, wb_dst == '0, ZERO_HARD != 0);
    port_clash = (SHARED != 0) && wb_live && (|rf_read);
    fe_hold    = ld_use || port_clash;
    ex_bubble  = fe_hold;

    if (ld_use) begin
      assert_interlock_R5: assert (fe_hold && ex_bubble);
    end
    if (port_clash) begin
      assert_port_wait_R9: assert (fe_hold && ex_bubble && wb_wr);
    end
  end

endmodule

// File: rtl/opnd_hazard_unit.sv
module opnd_hazard_unit
  import hzd_pkg::*;
#(
  parameter int REG_W              = 5,
  parameter int NUM_SRC            = 2,
  parameter int SHARED_RF_PORT     = 1,
  parameter int ZERO_REG_HARDWIRED = 1
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] of_src,
  input  logic [NUM_SRC-1:0]            of_src_vld,
  input  logic [REG_W-1:0]              ex_dst,
  input  logic                          ex_wr,
  input  logic                          ex_load,
  input  logic [REG_W-1:0]              wb_dst,
  input  logic                          wb_wr,
  input  logic                          wb_load,
  output logic [NUM_SRC-1:0][SEL_W-1:0] opnd_sel,
  output logic                          fe_hold,
  output logic                          ex_bubble
);

  logic [NUM_SRC-1:0] ld_wait;
  logic [NUM_SRC-1:0] rf_read;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
    opnd_src_e sel_k;
    hzd_match #(.REG_W(REG_W), .ZERO_HARD(ZERO_REG_HARDWIRED)) u_match (
      .src     (of_src[k]),
      .src_vld (of_src_vld[k]),
      .ex_dst  (ex_dst),
      .ex_wr   (ex_wr),
      .ex_load (ex_load),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_wr),
      .wb_load (wb_load),
      .sel     (sel_k),
      .ld_wait (ld_wait[k]),
      .rf_read (rf_read[k])
    );
    assign opnd_sel[k] = sel_k;
  end

  hzd_stall #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W),
    .SHARED(SHARED_RF_PORT), .ZERO_HARD(ZERO_REG_HARDWIRED)
  ) u_stall (
    .ld_wait   (ld_wait),
    .rf_read   (rf_read),
    .wb_dst    (wb_dst),
    .wb_wr     (wb_wr),
    .fe_hold   (fe_hold),
    .ex_bubble (ex_bubble)
  );

endmodule

// File: tb/sim_opnd_hazard_unit.sv
`timescale 1ns/1ps
module sim_opnd_hazard_unit;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0][4:0] of_src;
  logic [1:0]      of_src_vld;
  logic [4:0]      ex_dst, wb_dst;
  logic            ex_wr, ex_load, wb_wr, wb_load;
  logic [1:0][1:0] sel0, sel1;
  logic            hold0, bub0, hold1, bub1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  opnd_hazard_unit #(.SHARED_RF_PORT(1)) u0 (
    .of_src(of_src), .of_src_vld(of_src_vld), .ex_dst(ex_dst), .ex_wr(ex_wr),
    .ex_load(ex_load), .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_load(wb_load),
    .opnd_sel(sel0), .fe_hold(hold0), .ex_bubble(bub0));

  opnd_hazard_unit #(.SHARED_RF_PORT(0)) u1 (
    .of_src(of_src), .of_src_vld(of_src_vld), .ex_dst(ex_dst), .ex_wr(ex_wr),
    .ex_load(ex_load), .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_load(wb_load),
    .opnd_sel(sel1), .fe_hold(hold1), .ex_bubble(bub1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] s0, input logic v0, input logic [4:0] s1,
                       input logic v1, input logic [4:0] ed, input logic ew,
                       input logic el, input logic [4:0] wd, input logic ww,
                       input logic wl);
    @(negedge clk);
    of_src[0] = s0; of_src_vld[0] = v0; of_src[1] = s1; of_src_vld[1] = v1;
    ex_dst = ed; ex_wr = ew; ex_load = el; wb_dst = wd; wb_wr = ww; wb_load = wl;
    #1;
  endtask

  task automatic t_quiet_R1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 sel op0", sel0[0], 0); chk("R1 sel op1", sel0[1], 0);
    chk("R1 hold", hold0, 0);      chk("R1 bubble", bub0, 0);
    drive(3, 1, 4, 1, 9, 1, 0, 10, 0, 0);
    chk("R1 no match sel", sel1[0], 0); chk("R1 no match hold", hold1, 0);
  endtask

  task automatic t_alu_fwd_R2;
    drive(5, 1, 6, 1, 5, 1, 0, 0, 0, 0);
    chk("R2 sel op0", sel0[0], 1); chk("R2 sel op1", sel0[1], 0);
    chk("R2 hold", hold0, 0);
  endtask

  task automatic t_wb_fwd_R3;
    drive(7, 1, 0, 0, 0, 0, 0, 7, 1, 0);
    chk("R3 sel op0", sel0[0], 3);
    chk("R3/R9 forwarded, no port hold", hold0, 0);
  endtask

  task automatic t_load_fwd_R4;
    drive(0, 0, 7, 1, 0, 0, 0, 7, 1, 1);
    chk("R4 sel op1", sel0[1], 2); chk("R4 hold", hold1, 0);
  endtask

  task automatic t_load_use_R5;
    drive(1, 0, 9, 1, 9, 1, 1, 0, 0, 0);
    chk("R5 hold shared", hold0, 1); chk("R5 bubble shared", bub0, 1);
    chk("R5 hold split", hold1, 1);  chk("R5 bubble split", bub1, 1);
  endtask

  task automatic t_priority_R6;
    drive(4, 1, 0, 0, 4, 1, 0, 4, 1, 1);
    chk("R6 ex wins", sel0[0], 1);
    drive(4, 1, 0, 0, 4, 1, 1, 4, 1, 0);
    chk("R6 ex load wins hold", hold1, 1);
  endtask

  task automatic t_zero_R7;
    drive(0, 1, 0, 1, 0, 1, 0, 0, 1, 0);
    chk("R7 r0 sel op0", sel0[0], 0); chk("R7 r0 sel op1", sel0[1], 0);
    chk("R7 r0 no port hold", hold0, 0);
    drive(0, 1, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R7 r0 load no hold", hold1, 0);
  endtask

  task automatic t_ignore_R8;
    drive(5, 0, 0, 0, 5, 1, 1, 5, 1, 0);
    chk("R8 invalid src sel", sel1[0], 0); chk("R8 invalid src hold", hold1, 0);
    drive(5, 1, 0, 0, 5, 0, 1, 5, 0, 1);
    chk("R8 nonwriting sel", sel1[0], 0); chk("R8 nonwriting hold", hold1, 0);
  endtask

  task automatic t_port_R9;
    drive(3, 1, 0, 0, 0, 0, 0, 12, 1, 0);
    chk("R9 shared hold", hold0, 1);   chk("R9 shared bubble", bub0, 1);
    chk("R9 split hold", hold1, 0);
    drive(3, 1, 0, 0, 0, 0, 0, 12, 0, 0);
    chk("R9 no write no hold", hold0, 0);
  endtask

  task automatic t_mixed_R10;
    drive(5, 1, 8, 1, 5, 1, 0, 8, 1, 0);
    chk("R10 op0 alu", sel0[0], 1); chk("R10 op1 wb", sel0[1], 3);
    chk("R10 hold", hold0, 0);
    drive(8, 1, 5, 1, 5, 1, 0, 8, 1, 1);
    chk("R10 op0 load", sel1[0], 2); chk("R10 op1 alu", sel1[1], 1);
  endtask

  initial begin
    of_src = '0; of_src_vld = '0; ex_dst = '0; ex_wr = 0; ex_load = 0;
    wb_dst = '0; wb_wr = 0; wb_load = 0;
    repeat (2) @(posedge clk);
    t_quiet_R1;
    t_alu_fwd_R2;
    t_wb_fwd_R3;
    t_load_fwd_R4;
    t_load_use_R5;
    t_priority_R6;
    t_zero_R7;
    t_ignore_R8;
    t_port_R9;
    t_mixed_R10;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule